// File: doc/BRIEF.md
# Column-Bypass Unsigned Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits each and registers a product of `2*WIDTH` bits. The partial products are summed in a carry-save array of adder cells, arranged as in a Braun multiplier. Every cell in the diagonal that one multiplicand bit feeds is gated by that bit. When the bit is zero, the cell's adder inputs are forced low, its carry-out is held at zero and its sum output passes the sum from the row above through unchanged. Zeros in the multiplicand therefore freeze whole columns of the array. No correction stage is needed, because a bypassed column adds nothing to the sum.

A multiplicand made only of ones freezes nothing. For that operand the block recodes the multiplicand into signed digits: a zero is placed below its lowest bit and each adjacent bit pair is read. That value becomes +1 at weight 2^WIDTH and -1 at weight 2^0, so the product is formed as (B << WIDTH) - B. For the -1 digit the array runs with only column 0 active, and a subtractor applies the recoded result.

A caller presents both operands with `validIn` high for one cycle. The product, a flag and a vector of the active digit positions appear on the outputs one clock later. They stay there until the next accepted operation.

Top module: `colbyp_mult`

## Requirements
- R1: While `rstN` is low, and after reset until the first accepted operation, `validOut`, `product` and `colEn` are all zero.
- R2: `validOut` is high in exactly the cycle that follows a cycle with `validIn` high, and low otherwise.
- R3: For a multiplicand with at least one zero bit, `product` equals the unsigned product `multiplicand * multiplier` one cycle after `validIn`.
- R4: While no operation is accepted (`validIn` low), `product` and `colEn` keep the values of the last accepted operation.
- R5: For a multiplicand with at least one zero bit, `colEn` bit j (j < WIDTH) equals multiplicand bit j, and `colEn` bit WIDTH is 0.
- R6: For an all-ones multiplicand, `colEn` has exactly two bits set, bit WIDTH and bit 0 (value 2^WIDTH + 1).
- R7: For an all-ones multiplicand, `product` equals (multiplier << WIDTH) - multiplier, which is the true product.
- R8: A zero multiplicand gives a zero `product` and a zero `colEn` for any multiplier, because every column is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Accept the operands this cycle |
| multiplicand | input | WIDTH | Operand A; its bits gate the adder columns |
| multiplier | input | WIDTH | Operand B |
| validOut | output | 1 | Result registers were loaded in the previous cycle |
| product | output | 2*WIDTH | Registered unsigned product |
| colEn | output | WIDTH+1 | Registered active-column / recoded digit positions |

## Verification
The 4-bit build is driven through all 256 operand pairs, and the 8-bit build through random pairs plus forced edge operands. A broken bypass cell would leak a carry out of a frozen column, or drop the sum passing through it, and corrupt the product only for multiplicands that contain zeros. Multiplicands of zero and of all ones are the key edges. A wrong recode would miss the subtraction or flag the wrong digit positions, and a wrong all-zero path would leave stray active columns. Idle cycles between operations expose output registers that do not hold, and a valid flag that is late or sticky.

// File: rtl/colbyp_pkg.sv
package colbyp_pkg;
  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic capture;  // load the result registers this cycle
    logic recode;   // multiplicand is all ones: use signed-digit path
  } ctrlStrobes_t;
endpackage

// File: rtl/colbyp_cell.sv
// Gated adder cell of the array. With en low the adder sees only zeros,
// the carry-out is held at zero and the incoming sum passes straight down.
module colbyp_cell #(
  parameter bit HALF = 1'b0  // row with no live carry input
) (
  input  logic en,
  input  logic ppIn,
  input  logic sumIn,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut
);
  logic gatedPp;
  logic gatedSum;
  logic addSum;
  logic addCarry;

  assign gatedPp  = ppIn & en;
  assign gatedSum = sumIn & en;

  generate
    if (HALF) begin : g_half
      logic unusedCarry;
      assign unusedCarry = carryIn;
      assign addSum   = gatedPp ^ gatedSum;
      assign addCarry = gatedPp & gatedSum;
    end else begin : g_full
      logic gatedCarry;
      assign gatedCarry = carryIn & en;
      assign addSum   = gatedPp ^ gatedSum ^ gatedCarry;
      assign addCarry = (gatedPp & gatedSum) | (gatedPp & gatedCarry) |
                        (gatedSum & gatedCarry);
    end
  endgenerate

  assign sumOut   = en ? addSum : sumIn;
  assign carryOut = en ? addCarry : 1'b0;
endmodule

// File: rtl/colbyp_ctrl.sv
module colbyp_ctrl
  import colbyp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic [WIDTH-1:0] multiplicand,
  output ctrlStrobes_t     strobes,
  output logic             validOut
);
  logic allOnes;

  assign allOnes         = &multiplicand;
  assign strobes.capture = validIn;
  assign strobes.recode  = validIn & allOnes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
endmodule

// File: rtl/colbyp_datapath.sv
module colbyp_datapath
  import colbyp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic [WIDTH:0]     colEn
);
  localparam int PW = 2 * WIDTH;

  // Operand seen by the array: in recode mode only the -1 digit at
  // weight 2^0 is applied, so the array yields the multiplier itself.
  logic [WIDTH-1:0] arrayA;
  assign arrayA = strobes.recode ? {{(WIDTH-1){1'b0}}, 1'b1} : multiplicand;

  // sumRow[i][j]: sum leaving cell (i,j), weight i+j; index WIDTH is zero.
  // carryRow[i][j]: carry leaving cell (i,j), weight i+j+1.
  logic [WIDTH-1:0][WIDTH:0]   sumRow;
  logic [WIDTH-1:0][WIDTH-1:0] carryRow;

  genvar gi, gj;
  generate
    for (gj = 0; gj < WIDTH; gj++) begin : g_row0
      assign sumRow[0][gj]   = arrayA[gj] & multiplier[0];
      assign carryRow[0][gj] = 1'b0;
    end
    assign sumRow[0][WIDTH] = 1'b0;

    for (gi = 1; gi < WIDTH; gi++) begin : g_rows
      assign sumRow[gi][WIDTH] = 1'b0;
      for (gj = 0; gj < WIDTH; gj++) begin : g_cols
        colbyp_cell #(.HALF(gi == 1)) cell_i (
          .en      (arrayA[gj]),
          .ppIn    (arrayA[gj] & multiplier[gi]),
          .sumIn   (sumRow[gi-1][gj+1]),
          .carryIn (carryRow[gi-1][gj]),
          .sumOut  (sumRow[gi][gj]),
          .carryOut(carryRow[gi][gj])
        );
      end
    end
  endgenerate

  // Low half: bit i leaves the array at cell (i,0).
  logic [WIDTH-1:0] lowBits;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_low
      assign lowBits[gi] = sumRow[gi][0];
    end
  endgenerate

  // High half: merge the last row's sums and carries.
  logic [WIDTH:0] hiSum;
  assign hiSum = {1'b0, sumRow[WIDTH-1][WIDTH:1]} + {1'b0, carryRow[WIDTH-1]};

  logic [PW-1:0] arrayProd;
  assign arrayProd = {hiSum[WIDTH-1:0], lowBits};

  logic [PW-1:0]  prodNext;
  logic [WIDTH:0] colNext;
  assign prodNext = strobes.recode ?
                    ({multiplier, {WIDTH{1'b0}}} - arrayProd) : arrayProd;
  assign colNext  = strobes.recode ?
                    {1'b1, {(WIDTH-1){1'b0}}, 1'b1} : {1'b0, multiplicand};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
      colEn   <= '0;
    end else if (strobes.capture) begin
      product <= prodNext;
      colEn   <= colNext;
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> (hiSum[WIDTH] == 1'b0));
  // R3
  array_prod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.recode) |=>
      (product == PW'($past(multiplicand)) * PW'($past(multiplier))));
  // R7
  recode_prod_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.recode |=>
      (product == ({$past(multiplier), {WIDTH{1'b0}}} -
                   {{WIDTH{1'b0}}, $past(multiplier)})));
  // R6
  recode_cols_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.recode |=> ($countones(colEn) == 2 && colEn[WIDTH] && colEn[0]));
  // R4
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(product) && $stable(colEn)));
endmodule

// File: rtl/colbyp_mult.sv
module colbyp_mult
  import colbyp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               validOut,
  output logic [2*WIDTH-1:0] product,
  output logic [WIDTH:0]     colEn
);
  ctrlStrobes_t strobes;

  colbyp_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .validIn     (validIn),
    .multiplicand(multiplicand),
    .strobes     (strobes),
    .validOut    (validOut)
  );

  colbyp_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .multiplicand(multiplicand),
    .multiplier  (multiplier),
    .product     (product),
    .colEn       (colEn)
  );
endmodule

// File: tb/colbyp_mult_tb_top.sv
`timescale 1ns/1ps
module colbyp_mult_tb_top;
  typedef struct { int unsigned a; int unsigned b; } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       v4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       vo4;
  logic [7:0] p4;
  logic [4:0] c4;

  logic       v8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       vo8;
  logic [15:0] p8;
  logic [8:0]  c8;

  colbyp_mult #(.WIDTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .validIn(v4), .multiplicand(a4),
    .multiplier(b4), .validOut(vo4), .product(p4), .colEn(c4));

  colbyp_mult #(.WIDTH(8)) dutWide_i (
    .clk(clk), .rstN(rstN), .validIn(v8), .multiplicand(a8),
    .multiplier(b8), .validOut(vo8), .product(p8), .colEn(c8));

  int checks = 0;
  int failures = 0;
  bit done = 0;
  item_t q4[$];
  item_t q8[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Expected values from the requirements.
  function automatic longint expProd(int unsigned a, int unsigned b);
    return longint'(a) * longint'(b);
  endfunction
  function automatic longint expCol(int unsigned a, int w);
    if (a == (1 << w) - 1) return longint'((1 << w) | 1);
    return longint'(a);
  endfunction

  task automatic op4(input int unsigned a, input int unsigned b);
    item_t it;
    @(negedge clk);
    a4 = a[3:0]; b4 = b[3:0]; v4 = 1'b1;
    it.a = a; it.b = b; q4.push_back(it);
  endtask
  task automatic op8(input int unsigned a, input int unsigned b);
    item_t it;
    @(negedge clk);
    a8 = a[7:0]; b8 = b[7:0]; v8 = 1'b1;
    it.a = a; it.b = b; q8.push_back(it);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      v4 = 1'b0; v8 = 1'b0;
      a4 = 4'hF; b4 = 4'h9; a8 = 8'hFF; b8 = 8'h5A;  // ignored operands
    end
  endtask

  // Monitor for the 4-bit build.
  longint last4P = 0, last4C = 0;
  always @(posedge clk) begin
    bit expV;
    expV = v4;
    #1;
    if (rstN && !done) begin
      check(vo4 == expV, "R2", "validOut w4", vo4, expV);
      if (expV) begin
        item_t it;
        string tp, tc;
        it = q4.pop_front();
        tp = (it.a == 15) ? "R7" : ((it.a == 0) ? "R8" : "R3");
        tc = (it.a == 15) ? "R6" : ((it.a == 0) ? "R8" : "R5");
        last4P = expProd(it.a, it.b);
        last4C = expCol(it.a, 4);
        check(longint'(p4) == last4P, tp, "product w4", p4, last4P);
        check(longint'(c4) == last4C, tc, "colEn w4", c4, last4C);
      end else begin
        check(longint'(p4) == last4P, "R4", "held product w4", p4, last4P);
        check(longint'(c4) == last4C, "R4", "held colEn w4", c4, last4C);
      end
    end
  end

  // Monitor for the 8-bit build.
  longint last8P = 0, last8C = 0;
  always @(posedge clk) begin
    bit expV;
    expV = v8;
    #1;
    if (rstN && !done) begin
      check(vo8 == expV, "R2", "validOut w8", vo8, expV);
      if (expV) begin
        item_t it;
        string tp, tc;
        it = q8.pop_front();
        tp = (it.a == 255) ? "R7" : ((it.a == 0) ? "R8" : "R3");
        tc = (it.a == 255) ? "R6" : ((it.a == 0) ? "R8" : "R5");
        last8P = expProd(it.a, it.b);
        last8C = expCol(it.a, 8);
        check(longint'(p8) == last8P, tp, "product w8", p8, last8P);
        check(longint'(c8) == last8C, tc, "colEn w8", c8, last8C);
      end else begin
        check(longint'(p8) == last8P, "R4", "held product w8", p8, last8P);
        check(longint'(c8) == last8C, "R4", "held colEn w8", c8, last8C);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state during reset
    check(vo4 == 0 && p4 == 0 && c4 == 0, "R1", "reset w4",
          {vo4, p4, c4}, 0);
    check(vo8 == 0 && p8 == 0 && c8 == 0, "R1", "reset w8",
          {vo8, p8, c8}, 0);
    rstN = 1'b1;
    idle(3);
    // R1: still zero after reset before any operation
    check(p4 == 0 && c4 == 0, "R1", "post-reset w4", {p4, c4}, 0);
    check(p8 == 0 && c8 == 0, "R1", "post-reset w8", {p8, c8}, 0);

    // Exhaustive 4-bit sweep, idle gaps every 16 operations.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) op4(a, b);
      idle(2);
    end
    // Worked pattern: alternating zeros bypass columns 0 and 2.
    op4(4'b1010, 4'b1111);
    idle(2);

    // 8-bit edges and random pairs.
    op8(0, 8'hFF);
    op8(8'hFF, 8'hFF);
    op8(8'hFF, 0);
    op8(8'h7F, 8'hFF);
    op8(8'hFE, 8'h81);
    idle(2);
    for (int k = 0; k < 300; k++) begin
      int unsigned ra, rb;
      ra = $urandom_range(255);
      rb = $urandom_range(255);
      if (k % 37 == 0) ra = 255;
      op8(ra, rb);
      if (k % 11 == 0) idle(1);
    end
    idle(4);
    finishRun();
  end
endmodule